// File: doc/BRIEF.md
# Exception Acceptance and Vector Unit

This block sits beside the core pipeline and decides, cycle by cycle, whether an incoming event is taken: a general exception, a user break, a DMA address error or an interrupt request. When an event is taken, the unit issues a redirect with the handler address. It also saves the current status word and PC, sets the block bit in the status word, and writes the 12-bit event code into the matching event register. The same unit runs the return-from-exception sequence. That sequence restores the status word from its saved copy, leaves one cycle free for the delay-slot instruction, and then jumps to the saved PC.

The block bit in the status word controls what happens to each class of request while it is set:

- Interrupts wait, unless the core is in power-down, in which case they are taken and wake the core.
- DMA address errors are latched and wait.
- User breaks are thrown away.
- Any other general exception escalates to a reset-like jump to a fixed address.

The status register itself lives outside the block. Its write port is driven from this block's outputs. While a status write is in flight, the unit uses the value being written, so that a second event cannot slip in before the status register updates.

All outputs are registered. An event presented in cycle N shows up on the outputs in cycle N+1.

Top module: `exc_vector_unit`

## Requirements
- R1: A general exception (general request line or user break) taken while the block bit is 0 redirects to the vector base plus 0x100 and writes its code to the exception event register.
- R2: A taken interrupt redirects to the vector base plus 0x600 and writes its code to the interrupt event register.
- R3: Every taken event writes the status word with bit BL_POS (default 28, the block bit) set to 1. The cycle right after an acceptance already treats the block bit as 1, even though the status input has not yet updated.
- R4: While the block bit is 1 and power-down is low, a held interrupt request is not taken. It is taken once the block bit reads 0.
- R5: While the block bit is 1 and power-down is high, an interrupt is taken and the wake output pulses with the redirect.
- R6: On a normal acceptance, the saved-status and saved-PC writes fire together with the redirect. They carry the status word and PC that were presented in the cycle the event was seen.
- R7: A DMA address error pulse arriving while the block bit is 1 is latched. It is taken as a general exception, with its own code, once the block bit is 0.
- R8: A user break pulse arriving while the block bit is 1 is discarded and is never taken later.
- R9: Each acceptance writes exactly one of the two event registers, on bits 11:0.
- R10: A general exception arriving while the block bit is 1 redirects to 0xA0000000. It pulses the multiple-exception reset output, writes code 0x020 to the exception event register, and does not write the saved registers.
- R11: When several events arrive in one cycle, the order of priority is: multiple-exception reset, then general exception, then user break, then DMA address error, then interrupt.
- R12: A return strobe in cycle N produces a status write of the saved status in cycle N+1, with no redirect. Cycle N+2 carries no redirect and no status write. Cycle N+3 carries a redirect to the saved PC captured in cycle N. No event is taken during cycles N through N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Interrupt request (level, held by requester) |
| irq_code_i | input | 12 | Interrupt event code |
| dma_err_i | input | 1 | DMA address error pulse |
| dma_code_i | input | 12 | DMA address error code |
| ubrk_i | input | 1 | User break pulse |
| ubrk_code_i | input | 12 | User break code |
| gexc_i | input | 1 | Other general exception pulse |
| gexc_code_i | input | 12 | General exception code |
| vbr_i | input | 32 | Vector base value |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current PC |
| ssr_i | input | 32 | Saved status word |
| spc_i | input | 32 | Saved PC |
| pdown_i | input | 1 | Core is in power-down |
| rte_i | input | 1 | Return-from-exception strobe |
| redirect_o | output | 1 | Fetch redirect strobe |
| target_o | output | 32 | Redirect address |
| sr_wr_o | output | 1 | Status word write enable |
| sr_wdata_o | output | 32 | Status word write data |
| ssr_wr_o | output | 1 | Saved status write enable |
| ssr_wdata_o | output | 32 | Saved status write data |
| spc_wr_o | output | 1 | Saved PC write enable |
| spc_wdata_o | output | 32 | Saved PC write data |
| expevt_wr_o | output | 1 | Exception event register write enable |
| intevt_wr_o | output | 1 | Interrupt event register write enable |
| evt_code_o | output | 12 | Event code for the enabled event register |
| mreset_o | output | 1 | Multiple-exception reset strobe |
| wake_o | output | 1 | Leave power-down |

## Verification
The checker watches every cycle for these properties:

- The vector arithmetic for interrupts and general exceptions is correct.
- The fixed target and reset strobe of the multiple-exception case are correct.
- The two event registers are never written together.
- The block bit is set on every acceptance.
- The saved status and saved PC are captured from the previous cycle.
- The quiet delay-slot cycle follows the status restore.

Some behaviours can only be shown by the directed scenarios, because they depend on what happens or does not happen over many cycles:

- A request is held pending and taken later.
- A user break is lost for good.
- A DMA error is latched until the block bit clears.
- The forwarded block bit stops a back-to-back acceptance.
- The requests are ordered by priority.
- A held interrupt is taken only after the return jump.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN  = 32;
    localparam int CODEW = 12;

    localparam logic [XLEN-1:0]  GEN_OFS    = 32'h0000_0100;
    localparam logic [XLEN-1:0]  INT_OFS    = 32'h0000_0600;
    localparam logic [XLEN-1:0]  MULTI_VEC  = 32'hA000_0000;
    localparam logic [CODEW-1:0] MRST_CODE  = 12'h020;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_SLOT,
        RS_JUMP
    } rte_state_e;

    typedef struct packed {
        logic              redirect;
        logic [XLEN-1:0]   target;
        logic              sr_wr;
        logic [XLEN-1:0]   sr_data;
        logic              save;
        logic [XLEN-1:0]   save_sr;
        logic [XLEN-1:0]   save_pc;
        logic              exp_wr;
        logic              int_wr;
        logic [CODEW-1:0]  code;
        logic              mrst;
        logic              wake;
    } act_t;

    function automatic logic [XLEN-1:0] vec_at(input logic [XLEN-1:0] base,
                                               input logic [XLEN-1:0] ofs);
        return base + ofs;
    endfunction

    function automatic logic [XLEN-1:0] with_bit(input logic [XLEN-1:0] w,
                                                 input int unsigned pos);
        logic [XLEN-1:0] m;
        m = '0;
        m[pos] = 1'b1;
        return w | m;
    endfunction

endpackage

// File: rtl/exc_dma_hold.sv
module exc_dma_hold
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             err_i,
    input  logic [CODEW-1:0] code_i,
    input  logic             take_i,
    output logic             pend_o,
    output logic [CODEW-1:0] code_o
);
    logic             pend_q;
    logic [CODEW-1:0] code_q;

    // A fresh pulse is visible in the same cycle; it also replaces a stored code.
    assign pend_o = pend_q | err_i;
    assign code_o = err_i ? code_i : code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            code_q <= '0;
        end else if (take_i) begin
            pend_q <= 1'b0;
        end else if (err_i) begin
            pend_q <= 1'b1;
            code_q <= code_i;
        end
    end
endmodule

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
#(
    parameter int unsigned BL_POS = 28
)(
    input  logic             block_i,
    input  logic             bl_i,
    input  logic             pdown_i,
    input  logic             gexc_i,
    input  logic [CODEW-1:0] gexc_code_i,
    input  logic             ubrk_i,
    input  logic [CODEW-1:0] ubrk_code_i,
    input  logic             dma_i,
    input  logic [CODEW-1:0] dma_code_i,
    input  logic             irq_i,
    input  logic [CODEW-1:0] irq_code_i,
    input  logic [XLEN-1:0]  vbr_i,
    input  logic [XLEN-1:0]  sr_i,
    input  logic [XLEN-1:0]  pc_i,
    output act_t             act_o,
    output logic             dma_take_o
);
    logic [XLEN-1:0] sr_bl;

    assign sr_bl = with_bit(sr_i, BL_POS);

    always_comb begin
        act_o      = '0;
        dma_take_o = 1'b0;
        if (!block_i) begin
            if (gexc_i && bl_i) begin
                // escalation: reset-like jump, nothing saved
                act_o.redirect = 1'b1;
                act_o.target   = MULTI_VEC;
                act_o.sr_wr    = 1'b1;
                act_o.sr_data  = sr_bl;
                act_o.exp_wr   = 1'b1;
                act_o.code     = MRST_CODE;
                act_o.mrst     = 1'b1;
            end else if ((gexc_i || ubrk_i || dma_i) && !bl_i) begin
                act_o.redirect = 1'b1;
                act_o.target   = vec_at(vbr_i, GEN_OFS);
                act_o.sr_wr    = 1'b1;
                act_o.sr_data  = sr_bl;
                act_o.save     = 1'b1;
                act_o.save_sr  = sr_i;
                act_o.save_pc  = pc_i;
                act_o.exp_wr   = 1'b1;
                if (gexc_i)      act_o.code = gexc_code_i;
                else if (ubrk_i) act_o.code = ubrk_code_i;
                else begin
                    act_o.code = dma_code_i;
                    dma_take_o = 1'b1;
                end
            end else if (irq_i && (!bl_i || pdown_i)) begin
                act_o.redirect = 1'b1;
                act_o.target   = vec_at(vbr_i, INT_OFS);
                act_o.sr_wr    = 1'b1;
                act_o.sr_data  = sr_bl;
                act_o.save     = 1'b1;
                act_o.save_sr  = sr_i;
                act_o.save_pc  = pc_i;
                act_o.int_wr   = 1'b1;
                act_o.code     = irq_code_i;
                act_o.wake     = pdown_i;
            end
        end
    end
endmodule

// File: rtl/exc_rte_seq.sv
module exc_rte_seq
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [XLEN-1:0] spc_i,
    output logic            busy_o,
    output logic            jump_o,
    output logic [XLEN-1:0] spc_o
);
    rte_state_e      st_q;
    logic [XLEN-1:0] spc_q;

    assign busy_o = (st_q != RS_IDLE);
    assign jump_o = (st_q == RS_JUMP);
    assign spc_o  = spc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RS_IDLE;
            spc_q <= '0;
        end else begin
            unique case (st_q)
                RS_IDLE: if (start_i) begin
                    st_q  <= RS_SLOT;
                    spc_q <= spc_i;
                end
                RS_SLOT: st_q <= RS_JUMP;
                RS_JUMP: st_q <= RS_IDLE;
                default: st_q <= RS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter int unsigned BL_POS = 28
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req_i,
    input  logic [CODEW-1:0]  irq_code_i,
    input  logic              dma_err_i,
    input  logic [CODEW-1:0]  dma_code_i,
    input  logic              ubrk_i,
    input  logic [CODEW-1:0]  ubrk_code_i,
    input  logic              gexc_i,
    input  logic [CODEW-1:0]  gexc_code_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   ssr_i,
    input  logic [XLEN-1:0]   spc_i,
    input  logic              pdown_i,
    input  logic              rte_i,
    output logic              redirect_o,
    output logic [XLEN-1:0]   target_o,
    output logic              sr_wr_o,
    output logic [XLEN-1:0]   sr_wdata_o,
    output logic              ssr_wr_o,
    output logic [XLEN-1:0]   ssr_wdata_o,
    output logic              spc_wr_o,
    output logic [XLEN-1:0]   spc_wdata_o,
    output logic              expevt_wr_o,
    output logic              intevt_wr_o,
    output logic [CODEW-1:0]  evt_code_o,
    output logic              mreset_o,
    output logic              wake_o
);
    act_t             act_q, act_d, sel_act;
    logic             bl_eff, busy, start, blocked, jump;
    logic             dma_pend, dma_take;
    logic [CODEW-1:0] dma_code;
    logic [XLEN-1:0]  spc_held;

    // forward a status write still in flight
    assign bl_eff  = act_q.sr_wr ? act_q.sr_data[BL_POS] : sr_i[BL_POS];
    assign start   = rte_i && !busy;
    assign blocked = busy || start;

    exc_dma_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .err_i  (dma_err_i),
        .code_i (dma_code_i),
        .take_i (dma_take),
        .pend_o (dma_pend),
        .code_o (dma_code)
    );

    exc_select #(.BL_POS(BL_POS)) u_sel (
        .block_i     (blocked),
        .bl_i        (bl_eff),
        .pdown_i     (pdown_i),
        .gexc_i      (gexc_i),
        .gexc_code_i (gexc_code_i),
        .ubrk_i      (ubrk_i),
        .ubrk_code_i (ubrk_code_i),
        .dma_i       (dma_pend),
        .dma_code_i  (dma_code),
        .irq_i       (irq_req_i),
        .irq_code_i  (irq_code_i),
        .vbr_i       (vbr_i),
        .sr_i        (sr_i),
        .pc_i        (pc_i),
        .act_o       (sel_act),
        .dma_take_o  (dma_take)
    );

    exc_rte_seq u_rte (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .spc_i   (spc_i),
        .busy_o  (busy),
        .jump_o  (jump),
        .spc_o   (spc_held)
    );

    always_comb begin
        act_d = sel_act;
        if (start) begin
            act_d         = '0;
            act_d.sr_wr   = 1'b1;
            act_d.sr_data = ssr_i;
        end else if (jump) begin
            act_d          = '0;
            act_d.redirect = 1'b1;
            act_d.target   = spc_held;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) act_q <= '0;
        else     act_q <= act_d;
    end

    assign redirect_o  = act_q.redirect;
    assign target_o    = act_q.target;
    assign sr_wr_o     = act_q.sr_wr;
    assign sr_wdata_o  = act_q.sr_data;
    assign ssr_wr_o    = act_q.save;
    assign ssr_wdata_o = act_q.save_sr;
    assign spc_wr_o    = act_q.save;
    assign spc_wdata_o = act_q.save_pc;
    assign expevt_wr_o = act_q.exp_wr;
    assign intevt_wr_o = act_q.int_wr;
    assign evt_code_o  = act_q.code;
    assign mreset_o    = act_q.mrst;
    assign wake_o      = act_q.wake;
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk
    import exc_pkg::*;
#(
    parameter int unsigned BL_POS = 28
)(
    input logic             clk,
    input logic             rst,
    input logic [XLEN-1:0]  vbr_i,
    input logic [XLEN-1:0]  sr_i,
    input logic [XLEN-1:0]  pc_i,
    input logic             redirect_o,
    input logic [XLEN-1:0]  target_o,
    input logic             sr_wr_o,
    input logic [XLEN-1:0]  sr_wdata_o,
    input logic             ssr_wr_o,
    input logic [XLEN-1:0]  ssr_wdata_o,
    input logic             spc_wr_o,
    input logic [XLEN-1:0]  spc_wdata_o,
    input logic             expevt_wr_o,
    input logic             intevt_wr_o,
    input logic             mreset_o
);
    assert_gen_vector_R1: assert property (@(posedge clk) disable iff (rst)
        (expevt_wr_o && !mreset_o) |-> (redirect_o && target_o == $past(vbr_i) + GEN_OFS));

    assert_int_vector_R2: assert property (@(posedge clk) disable iff (rst)
        intevt_wr_o |-> (redirect_o && target_o == $past(vbr_i) + INT_OFS));

    assert_bl_set_R3: assert property (@(posedge clk) disable iff (rst)
        (expevt_wr_o || intevt_wr_o) |-> (sr_wr_o && sr_wdata_o[BL_POS]));

    assert_save_pair_R6: assert property (@(posedge clk) disable iff (rst)
        ssr_wr_o |-> (spc_wr_o && redirect_o && ssr_wdata_o == $past(sr_i)
                      && spc_wdata_o == $past(pc_i)));

    assert_one_evt_reg_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({expevt_wr_o, intevt_wr_o}));

    assert_mrst_vector_R10: assert property (@(posedge clk) disable iff (rst)
        mreset_o |-> (redirect_o && target_o == MULTI_VEC && !ssr_wr_o && expevt_wr_o));

    assert_rte_slot_R12: assert property (@(posedge clk) disable iff (rst)
        (sr_wr_o && !redirect_o) |=> (!redirect_o && !sr_wr_o));
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.BL_POS(BL_POS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vbr_i       (vbr_i),
    .sr_i        (sr_i),
    .pc_i        (pc_i),
    .redirect_o  (redirect_o),
    .target_o    (target_o),
    .sr_wr_o     (sr_wr_o),
    .sr_wdata_o  (sr_wdata_o),
    .ssr_wr_o    (ssr_wr_o),
    .ssr_wdata_o (ssr_wdata_o),
    .spc_wr_o    (spc_wr_o),
    .spc_wdata_o (spc_wdata_o),
    .expevt_wr_o (expevt_wr_o),
    .intevt_wr_o (intevt_wr_o),
    .mreset_o    (mreset_o)
);

// File: tb/tb_exc_vector_unit.sv
`timescale 1ns/1ps
module tb_exc_vector_unit;
    localparam logic [31:0] VBR  = 32'h8C00_0000;
    localparam logic [31:0] BASE = 32'h0000_00F0;
    localparam logic [31:0] BLM  = 32'h1000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        irq_req_i = 0, dma_err_i = 0, ubrk_i = 0, gexc_i = 0, pdown_i = 0, rte_i = 0;
    logic [11:0] irq_code_i = 0, dma_code_i = 0, ubrk_code_i = 0, gexc_code_i = 0;
    logic [31:0] vbr_i = VBR, pc_i = 32'h0000_4000, ssr_i = 0, spc_i = 0;
    logic [31:0] sr;
    logic        sr_load = 0;
    logic [31:0] sr_load_val = 0;

    logic        redirect_o, sr_wr_o, ssr_wr_o, spc_wr_o, expevt_wr_o, intevt_wr_o, mreset_o, wake_o;
    logic [31:0] target_o, sr_wdata_o, ssr_wdata_o, spc_wdata_o;
    logic [11:0] evt_code_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    exc_vector_unit dut (
        .clk(clk), .rst(rst),
        .irq_req_i(irq_req_i), .irq_code_i(irq_code_i),
        .dma_err_i(dma_err_i), .dma_code_i(dma_code_i),
        .ubrk_i(ubrk_i), .ubrk_code_i(ubrk_code_i),
        .gexc_i(gexc_i), .gexc_code_i(gexc_code_i),
        .vbr_i(vbr_i), .sr_i(sr), .pc_i(pc_i), .ssr_i(ssr_i), .spc_i(spc_i),
        .pdown_i(pdown_i), .rte_i(rte_i),
        .redirect_o(redirect_o), .target_o(target_o),
        .sr_wr_o(sr_wr_o), .sr_wdata_o(sr_wdata_o),
        .ssr_wr_o(ssr_wr_o), .ssr_wdata_o(ssr_wdata_o),
        .spc_wr_o(spc_wr_o), .spc_wdata_o(spc_wdata_o),
        .expevt_wr_o(expevt_wr_o), .intevt_wr_o(intevt_wr_o),
        .evt_code_o(evt_code_o), .mreset_o(mreset_o), .wake_o(wake_o)
    );

    // status register model outside the block
    always @(posedge clk) begin
        if (rst)           sr <= BASE;
        else if (sr_load)  sr <= sr_load_val;
        else if (sr_wr_o)  sr <= sr_wdata_o;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_sr(input logic [31:0] v);
        sr_load = 1; sr_load_val = v;
        step();
        sr_load = 0;
    endtask

    task automatic quiet();
        irq_req_i = 0; dma_err_i = 0; ubrk_i = 0; gexc_i = 0; pdown_i = 0; rte_i = 0;
        set_sr(BASE);
        step();
    endtask

    task automatic t_reset();
        chk("R3", "redirect after reset", {31'b0, redirect_o}, 0);
        chk("R9", "event writes after reset", {30'b0, expevt_wr_o, intevt_wr_o}, 0);
    endtask

    task automatic t_general();
        quiet();
        gexc_i = 1; gexc_code_i = 12'h1E0; pc_i = 32'h0000_4444;
        step();
        gexc_i = 0;
        chk("R1", "gen redirect", {31'b0, redirect_o}, 1);
        chk("R1", "gen target", target_o, VBR + 32'h100);
        chk("R1", "gen expevt code", {19'b0, expevt_wr_o, evt_code_o}, {19'b0, 1'b1, 12'h1E0});
        chk("R9", "gen no intevt", {31'b0, intevt_wr_o}, 0);
        chk("R3", "gen sets block bit", {31'b0, sr_wr_o}, 1);
        chk("R3", "gen sr data", sr_wdata_o, BASE | BLM);
        chk("R6", "gen ssr", ssr_wdata_o, BASE);
        chk("R6", "gen spc", spc_wdata_o, 32'h0000_4444);
        chk("R6", "gen save strobes", {30'b0, ssr_wr_o, spc_wr_o}, 3);
        // interrupt raised while status write is still in flight
        irq_req_i = 1; irq_code_i = 12'h400;
        step();
        chk("R3", "forwarded block bit stops irq", {31'b0, redirect_o}, 0);
        irq_req_i = 0;
    endtask

    task automatic t_irq();
        quiet();
        irq_req_i = 1; irq_code_i = 12'h520;
        step();
        irq_req_i = 0;
        chk("R2", "irq target", target_o, VBR + 32'h600);
        chk("R2", "irq intevt code", {19'b0, intevt_wr_o, evt_code_o}, {19'b0, 1'b1, 12'h520});
        chk("R9", "irq no expevt", {31'b0, expevt_wr_o}, 0);
        chk("R5", "no wake when awake", {31'b0, wake_o}, 0);
    endtask

    task automatic t_irq_held();
        quiet();
        set_sr(BASE | BLM);
        irq_req_i = 1; irq_code_i = 12'h540;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R4", "irq held under block bit", {31'b0, redirect_o}, 0);
        end
        set_sr(BASE);
        chk("R4", "irq still held on clear edge", {31'b0, redirect_o}, 0);
        step();
        chk("R4", "irq taken after clear", {31'b0, intevt_wr_o, redirect_o}, 3);
        chk("R4", "irq held target", target_o, VBR + 32'h600);
        irq_req_i = 0;
    endtask

    task automatic t_pdown();
        quiet();
        set_sr(BASE | BLM);
        irq_req_i = 1; pdown_i = 1; irq_code_i = 12'h560;
        step();
        irq_req_i = 0; pdown_i = 0;
        chk("R5", "pdown irq taken", {31'b0, intevt_wr_o}, 1);
        chk("R5", "pdown wake", {31'b0, wake_o}, 1);
        chk("R5", "pdown target", target_o, VBR + 32'h600);
    endtask

    task automatic t_dma();
        quiet();
        set_sr(BASE | BLM);
        dma_err_i = 1; dma_code_i = 12'h5C0;
        step();
        dma_err_i = 0;
        chk("R7", "dma held under block bit", {31'b0, redirect_o}, 0);
        step();
        chk("R7", "dma still held", {31'b0, redirect_o}, 0);
        set_sr(BASE);
        step();
        chk("R7", "dma taken after clear", {31'b0, expevt_wr_o}, 1);
        chk("R7", "dma code", {20'b0, evt_code_o}, 32'h5C0);
        chk("R7", "dma target", target_o, VBR + 32'h100);
    endtask

    task automatic t_ubrk();
        quiet();
        set_sr(BASE | BLM);
        ubrk_i = 1; ubrk_code_i = 12'h1E0;
        step();
        ubrk_i = 0;
        chk("R8", "ubrk dropped", {31'b0, redirect_o}, 0);
        set_sr(BASE);
        step();
        chk("R8", "ubrk not taken later", {31'b0, redirect_o}, 0);
        step();
        chk("R8", "ubrk still not taken", {31'b0, expevt_wr_o}, 0);
        ubrk_i = 1; ubrk_code_i = 12'h1E1;
        step();
        ubrk_i = 0;
        chk("R1", "ubrk taken unblocked", {20'b0, evt_code_o}, 32'h1E1);
        chk("R1", "ubrk target", target_o, VBR + 32'h100);
    endtask

    task automatic t_multi();
        quiet();
        set_sr(BASE | BLM);
        gexc_i = 1; gexc_code_i = 12'h0E0;
        step();
        gexc_i = 0;
        chk("R10", "mreset strobe", {31'b0, mreset_o}, 1);
        chk("R10", "mreset target", target_o, 32'hA000_0000);
        chk("R10", "mreset code", {19'b0, expevt_wr_o, evt_code_o}, {19'b0, 1'b1, 12'h020});
        chk("R10", "mreset no save", {30'b0, ssr_wr_o, spc_wr_o}, 0);
    endtask

    task automatic t_priority();
        quiet();
        gexc_i = 1; gexc_code_i = 12'h180;
        dma_err_i = 1; dma_code_i = 12'h5C0;
        irq_req_i = 1; irq_code_i = 12'h600;
        step();
        gexc_i = 0; dma_err_i = 0;
        chk("R11", "general wins", {20'b0, evt_code_o}, 32'h180);
        set_sr(BASE);
        step();
        chk("R11", "dma second", {20'b0, evt_code_o}, 32'h5C0);
        chk("R11", "dma on expevt", {31'b0, expevt_wr_o}, 1);
        set_sr(BASE);
        step();
        chk("R11", "irq last", {31'b0, intevt_wr_o}, 1);
        irq_req_i = 0;
    endtask

    task automatic t_rte();
        quiet();
        set_sr(BASE | BLM);
        ssr_i = 32'h0000_0033; spc_i = 32'h1234_5678;
        irq_req_i = 1; irq_code_i = 12'h620;
        rte_i = 1;
        step();
        rte_i = 0; spc_i = 32'hDEAD_0000;
        chk("R12", "restore status", {31'b0, sr_wr_o}, 1);
        chk("R12", "restore data", sr_wdata_o, 32'h0000_0033);
        chk("R12", "no redirect on restore", {31'b0, redirect_o}, 0);
        step();
        chk("R12", "slot cycle quiet", {30'b0, redirect_o, sr_wr_o}, 0);
        step();
        chk("R12", "jump to saved pc", target_o, 32'h1234_5678);
        chk("R12", "jump not an event", {30'b0, redirect_o, intevt_wr_o}, 2);
        step();
        chk("R12", "irq after jump", {31'b0, intevt_wr_o}, 1);
        irq_req_i = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        step();
        t_reset();
        t_general();
        t_irq();
        t_irq_held();
        t_pdown();
        t_dma();
        t_ubrk();
        t_multi();
        t_priority();
        t_rte();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule